// File: doc/BRIEF.md
# Interrupt Coalescing Status Controller

This block sits between a network device's event sources and the single interrupt line to the host processor. It holds an event status register and an event mask register. Device events arrive as one-cycle pulse vectors and set status bits. Software clears bits, rewrites the mask and gates all posting with a level enable input. The line is asserted only when the enable is high and some bit is set in both status and mask.

Assertion of the line can be deferred by a programmable number of cycles. Several events then share one interrupt. Events in an urgent class skip the wait. Two watermark events only count toward a post while their level condition still holds. While the line is already up, a new post leaves it as it is. A command input can raise the software event or restore the reset state. Every input is a plain control pin with no handshake. The block never stalls its sources, and an event pulse is taken in the cycle it appears.

Top module: `irq_coalesce_ctrl`

## Requirements
- R1: A cycle's `evt_post_i` vector is ORed into the status register at the next clock edge. `cmd_intr_i` sets status bit 0 (software event). `status_o` shows the result one cycle later.
- R2: When `clr_valid_i` is high, the bits of `clr_bits_i` are removed from the status register. If the same bit is both posted and cleared in one cycle, the clear wins.
- R3: Bits 15..12 are reserved. A post vector or clear vector that touches any of them is discarded whole and leaves the status unchanged. `rsv_err_o` is high in the following cycle.
- R4: `irq_o` is low whenever (status AND mask) is zero. A clear or mask write that zeroes it drops the line at that edge and cancels any deferred post.
- R5: Writing a mask equal to the current mask changes nothing. After a write that changes the mask, the line goes high at that edge if (status AND mask) is non-zero and the enable is high.
- R6: A posted bit that is in the urgent class (bits 0 and 7) and that passes the mask raises the line at the next edge, whatever the delay setting.
- R7: A non-urgent masked post raises the line `delay_i` edges after the edge that took the event. A delay of 0 means that same edge.
- R8: If a deferred post is already armed, a new request replaces it only when the new one would fire earlier. Otherwise the armed time stands.
- R9: With `int_en_i` low, the line is low and nothing is armed. The rising edge of `int_en_i` raises the line at once if (status AND mask) is non-zero.
- R10: While `irq_o` is high, further posts and partial clears leave it high. The line stays high as long as (status AND mask) is non-zero.
- R11: A post of receive-high-watermark (bit 1) does not trigger unless `rx_above_high_i` is high. A post of transmit-low-watermark (bit 3) does not trigger unless `tx_below_low_i` is high. The status bit is set in either case.
- R12: After reset or `cmd_reset_i`, status is 0 and the mask is 0x000F (bits 0..3), with the line low and nothing armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_post_i | input | NB | One-cycle event pulses to set in status |
| clr_valid_i | input | 1 | Apply a status clear this cycle |
| clr_bits_i | input | NB | Status bits to clear |
| mask_wr_i | input | 1 | Load the mask this cycle |
| mask_data_i | input | NB | New mask value |
| int_en_i | input | 1 | Global interrupt enable level |
| cmd_intr_i | input | 1 | Raise the software event |
| cmd_reset_i | input | 1 | Return to the reset state |
| delay_i | input | DW | Coalescing delay in cycles |
| rx_above_high_i | input | 1 | Receive level still above its high watermark |
| tx_below_low_i | input | 1 | Transmit level still below its low watermark |
| irq_o | output | 1 | Interrupt line to the host |
| status_o | output | NB | Status register |
| mask_o | output | NB | Mask register |
| rsv_err_o | output | 1 | Reserved-bit access flagged last cycle |

## Verification
The posting path is driven with a single urgent event, a lone non-urgent event, and pairs of deferred requests where the second is either earlier or later than the first. These cases show whether the line follows the bypass, the delay count, or the keep-the-earliest rule. Masked-out events, rejected watermark events and reserved-bit vectors each set or leave status bits without moving the line. This separates status bookkeeping from the posting decision. Enable toggles and mask writes are tried with pending bits present and absent, to show both re-evaluation and the pass-through of identical writes.

// File: rtl/icsc_pkg.sv
package icsc_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // Event bit positions decoded by the posting logic
  localparam int EV_SOFT    = 0;
  localparam int EV_RX_HIGH = 1;
  localparam int EV_RX_PKT  = 2;
  localparam int EV_TX_LOW  = 3;
  localparam int EV_TX_PKT  = 4;
  localparam int EV_LINK    = 7;

  typedef enum logic [2:0] {
    ACT_HOLD,   // keep state, count down if armed
    ACT_DROP,   // lower line, disarm
    ACT_KEEP,   // line already high
    ACT_NOW,    // raise line at this edge
    ACT_ARM     // load a new deferral
  } post_act_e;
endpackage

// File: rtl/icsc_event_regs.sv
module icsc_event_regs
  import icsc_pkg::*;
#(
  parameter int              NB         = 16,
  parameter logic [NB-1:0]   RSV_MASK   = 16'hF000,
  parameter logic [NB-1:0]   RESET_MASK = 16'h000F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] evt_post_i,
  input  logic          clr_valid_i,
  input  logic [NB-1:0] clr_bits_i,
  input  logic          mask_wr_i,
  input  logic [NB-1:0] mask_data_i,
  input  logic          cmd_intr_i,
  input  logic          cmd_reset_i,
  output logic [NB-1:0] status_q,
  output logic [NB-1:0] mask_q,
  output logic [NB-1:0] status_n,
  output logic [NB-1:0] mask_n,
  output logic [NB-1:0] post_acc,
  output logic          mask_chg,
  output logic          rsv_err_q
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [NB-1:0] SOFT_BIT = NB'(1) << EV_SOFT;

  logic          rsv_post, rsv_clr;
  logic [NB-1:0] clr_acc;

  always_comb begin
    rsv_post = |(evt_post_i & RSV_MASK);
    rsv_clr  = clr_valid_i && (|(clr_bits_i & RSV_MASK));
    post_acc = (rsv_post ? '0 : evt_post_i) | (cmd_intr_i ? SOFT_BIT : '0);
    clr_acc  = (clr_valid_i && !rsv_clr) ? clr_bits_i : '0;
    status_n = (status_q | post_acc) & ~clr_acc;
    mask_n   = mask_wr_i ? mask_data_i : mask_q;
    mask_chg = mask_wr_i && (mask_data_i != mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q  <= '0;
      mask_q    <= RESET_MASK;
      rsv_err_q <= 1'b0;
    end else if (cmd_reset_i) begin
      status_q  <= '0;
      mask_q    <= RESET_MASK;
      rsv_err_q <= 1'b0;
    end else begin
      status_q  <= status_n;
      mask_q    <= mask_n;
      rsv_err_q <= rsv_post | rsv_clr;
    end
  end

  // R3
  rsv_never_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & RSV_MASK) == '0);

  // R3
  rsv_clear_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid_i && (|(clr_bits_i & RSV_MASK)) && evt_post_i == '0 && !cmd_intr_i && !cmd_reset_i)
      |=> $stable(status_q));

  // R5
  same_mask_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr_i && mask_data_i == mask_q && !cmd_reset_i) |=> $stable(mask_q));
endmodule

// File: rtl/icsc_post_filter.sv
module icsc_post_filter
  import icsc_pkg::*;
#(
  parameter int            NB           = 16,
  parameter logic [NB-1:0] NODELAY_MASK = 16'h0081
) (
  input  logic [NB-1:0] post_acc,
  input  logic [NB-1:0] status_n,
  input  logic [NB-1:0] mask_n,
  input  logic          rx_above_high_i,
  input  logic          tx_below_low_i,
  output logic          trig_any,
  output logic          trig_urgent,
  output logic          masked_any
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [NB-1:0] gate;
  logic [NB-1:0] trig;

  // Per-bit qualifier: watermark events count only while their level holds
  for (genvar b = 0; b < NB; b++) begin : g_gate
    if (b == EV_RX_HIGH) begin : g_rxh
      assign gate[b] = rx_above_high_i;
    end else if (b == EV_TX_LOW) begin : g_txl
      assign gate[b] = tx_below_low_i;
    end else begin : g_pass
      assign gate[b] = 1'b1;
    end
  end

  always_comb begin
    trig        = post_acc & status_n & mask_n & gate;
    trig_any    = |trig;
    trig_urgent = |(trig & NODELAY_MASK);
    masked_any  = |(status_n & mask_n);
  end
endmodule

// File: rtl/icsc_sched.sv
module icsc_sched
  import icsc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_reset_i,
  input  logic          int_en_i,
  input  logic          masked_any,
  input  logic          mask_chg,
  input  logic          trig_any,
  input  logic          trig_urgent,
  input  logic [DW-1:0] delay_i,
  output logic          irq_q
);
  timeunit 1ns;
  timeprecision 1ps;

  logic          en_q, run_q;
  logic [DW-1:0] cnt_q;
  logic          en_rise, fire_now, new_earlier;
  post_act_e     act;

  always_comb begin
    en_rise     = int_en_i && !en_q;
    fire_now    = run_q && (cnt_q == DW'(1));
    // armed request fires cnt_q-1 edges from now; a new one fires delay_i edges from now
    new_earlier = !run_q || (({1'b0, delay_i} + (DW+1)'(1)) < {1'b0, cnt_q});
    if (!int_en_i || !masked_any)                  act = ACT_DROP;
    else if (irq_q)                                act = ACT_KEEP;
    else if (mask_chg || en_rise || trig_urgent)   act = ACT_NOW;
    else if (fire_now)                             act = ACT_NOW;
    else if (trig_any && new_earlier)
      act = (delay_i == '0) ? ACT_NOW : ACT_ARM;
    else                                           act = ACT_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      run_q <= 1'b0;
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      en_q <= int_en_i;
      if (cmd_reset_i) begin
        run_q <= 1'b0;
        cnt_q <= '0;
        irq_q <= 1'b0;
      end else begin
        unique case (act)
          ACT_DROP: begin irq_q <= 1'b0; run_q <= 1'b0; cnt_q <= '0; end
          ACT_KEEP: begin run_q <= 1'b0; cnt_q <= '0; end
          ACT_NOW:  begin irq_q <= 1'b1; run_q <= 1'b0; cnt_q <= '0; end
          ACT_ARM:  begin run_q <= 1'b1; cnt_q <= delay_i; end
          default:  if (run_q) cnt_q <= cnt_q - DW'(1);
        endcase
      end
    end
  end

  // R9
  no_post_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en_i |=> !irq_q);

  // R7
  armed_count_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q != '0 && !irq_q));

  // R6
  urgent_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_urgent && int_en_i && masked_any && !cmd_reset_i) |=> irq_q);

  // R10
  pending_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && int_en_i && masked_any && !cmd_reset_i) |=> irq_q);
endmodule

// File: rtl/irq_coalesce_ctrl.sv
module irq_coalesce_ctrl
  import icsc_pkg::*;
#(
  parameter int            NB           = 16,
  parameter int            DW           = 16,
  parameter logic [NB-1:0] RSV_MASK     = 16'hF000,
  parameter logic [NB-1:0] NODELAY_MASK = 16'h0081
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] evt_post_i,
  input  logic          clr_valid_i,
  input  logic [NB-1:0] clr_bits_i,
  input  logic          mask_wr_i,
  input  logic [NB-1:0] mask_data_i,
  input  logic          int_en_i,
  input  logic          cmd_intr_i,
  input  logic          cmd_reset_i,
  input  logic [DW-1:0] delay_i,
  input  logic          rx_above_high_i,
  input  logic          tx_below_low_i,
  output logic          irq_o,
  output logic [NB-1:0] status_o,
  output logic [NB-1:0] mask_o,
  output logic          rsv_err_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [NB-1:0] RESET_MASK = (NB'(1) << EV_SOFT) | (NB'(1) << EV_RX_HIGH) |
                                         (NB'(1) << EV_RX_PKT) | (NB'(1) << EV_TX_LOW);

  logic [NB-1:0] status_n, mask_n, post_acc;
  logic          mask_chg, trig_any, trig_urgent, masked_any;

  icsc_event_regs #(.NB(NB), .RSV_MASK(RSV_MASK), .RESET_MASK(RESET_MASK)) u_regs (
    .clk, .rst_n, .evt_post_i, .clr_valid_i, .clr_bits_i, .mask_wr_i, .mask_data_i,
    .cmd_intr_i, .cmd_reset_i,
    .status_q(status_o), .mask_q(mask_o), .status_n, .mask_n, .post_acc,
    .mask_chg, .rsv_err_q(rsv_err_o)
  );

  icsc_post_filter #(.NB(NB), .NODELAY_MASK(NODELAY_MASK)) u_filter (
    .post_acc, .status_n, .mask_n, .rx_above_high_i, .tx_below_low_i,
    .trig_any, .trig_urgent, .masked_any
  );

  icsc_sched #(.DW(DW)) u_sched (
    .clk, .rst_n, .cmd_reset_i, .int_en_i, .masked_any, .mask_chg,
    .trig_any, .trig_urgent, .delay_i, .irq_q(irq_o)
  );

  // R4
  line_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_o & mask_o) == '0) |-> !irq_o);
endmodule

// File: tb/tb_irq_coalesce_ctrl.sv
module tb_irq_coalesce_ctrl;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NB = 16;
  localparam int DW = 16;
  localparam logic [15:0] RSV = 16'hF000;
  localparam logic [15:0] NOD = 16'h0081;
  localparam logic [15:0] RMASK = 16'h000F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB-1:0] evt_post = '0, clr_bits = '0, mask_data = '0;
  logic clr_valid = 1'b0, mask_wr = 1'b0, int_en = 1'b0, cmd_intr = 1'b0, cmd_reset = 1'b0;
  logic [DW-1:0] delay = '0;
  logic rx_hi = 1'b1, tx_lo = 1'b1;
  logic irq, rsv_err;
  logic [NB-1:0] status, mask;

  int checks = 0, fails = 0;
  bit chk_en = 1'b0;
  string phase = "R12";

  always #2.5 clk = ~clk;

  irq_coalesce_ctrl dut (
    .clk, .rst_n, .evt_post_i(evt_post), .clr_valid_i(clr_valid), .clr_bits_i(clr_bits),
    .mask_wr_i(mask_wr), .mask_data_i(mask_data), .int_en_i(int_en), .cmd_intr_i(cmd_intr),
    .cmd_reset_i(cmd_reset), .delay_i(delay), .rx_above_high_i(rx_hi),
    .tx_below_low_i(tx_lo), .irq_o(irq), .status_o(status), .mask_o(mask), .rsv_err_o(rsv_err)
  );

  // Behavioural reference: absolute edge numbers for the deferred post
  logic [15:0] m_status, m_mask;
  bit m_irq, m_err, m_en_prev;
  int m_fire = -1;
  int edge_n = 0;

  always @(posedge clk) begin
    logic [15:0] p, c, masked, trig;
    bit rp, rc, mchg, rise;
    if (!rst_n || cmd_reset) begin
      m_status = '0; m_mask = RMASK; m_irq = 0; m_err = 0; m_fire = -1;
      m_en_prev = rst_n ? int_en : 1'b0;
    end else begin
      p = evt_post; rp = (p & RSV) != 0; if (rp) p = '0;
      if (cmd_intr) p = p | 16'h0001;
      c = clr_valid ? clr_bits : '0; rc = (c & RSV) != 0; if (rc) c = '0;
      m_err = rp || rc;
      mchg = mask_wr && (mask_data != m_mask);
      if (mask_wr) m_mask = mask_data;
      m_status = (m_status | p) & ~c;
      masked = m_status & m_mask;
      trig = p & masked;
      if (!rx_hi) trig = trig & ~16'h0002;
      if (!tx_lo) trig = trig & ~16'h0008;
      rise = int_en && !m_en_prev;
      m_en_prev = int_en;
      if (!int_en || masked == 0) begin m_irq = 0; m_fire = -1; end
      else if (m_irq) m_fire = -1;
      else if (mchg || rise || (trig & NOD) != 0) begin m_irq = 1; m_fire = -1; end
      else if (m_fire == edge_n) begin m_irq = 1; m_fire = -1; end
      else if (trig != 0) begin
        if (delay == 0) begin m_irq = 1; m_fire = -1; end
        else if (m_fire < 0 || edge_n + int'(delay) < m_fire) m_fire = edge_n + int'(delay);
      end
    end
    edge_n++;
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) if (chk_en) begin
    chk("irq", int'(irq), int'(m_irq));
    chk("status", int'(status), int'(m_status));
    chk("mask", int'(mask), int'(m_mask));
    chk("rsv_err", int'(rsv_err), int'(m_err));
  end

  task automatic tick(int n = 1); repeat (n) @(negedge clk); endtask
  task automatic post(logic [15:0] v); evt_post = v; tick(); evt_post = '0; endtask
  task automatic clr(logic [15:0] v); clr_valid = 1; clr_bits = v; tick(); clr_valid = 0; clr_bits = '0; endtask
  task automatic mwr(logic [15:0] v); mask_wr = 1; mask_data = v; tick(); mask_wr = 0; endtask
  task automatic cmdi(); cmd_intr = 1; tick(); cmd_intr = 0; endtask
  task automatic cmdr(); cmd_reset = 1; tick(); cmd_reset = 0; endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    tick(3); rst_n = 1; tick(1); chk_en = 1;
    phase = "R12"; tick(2);                         // reset values: status 0, mask 000F
    phase = "R1";  post(16'h0014); tick(); cmdi(); tick(2);
    post(16'h0010); tick();                         // bit 4 outside mask
    phase = "R2";  clr(16'h0010); tick();
    phase = "R3";  post(16'h1002); tick(); clr(16'h8001); tick(2);
    phase = "R2";  clr(16'h00FF); tick();
    phase = "R9";  int_en = 1; tick(3);             // rise with nothing pending
    phase = "R7";  delay = 5; post(16'h0004); tick(8);
    phase = "R4";  clr(16'h0004); tick(2);
    phase = "R6";  delay = 20; cmdi(); tick(2); clr(16'h0001); tick();
    phase = "R8";  delay = 10; post(16'h0004); tick(3); delay = 2; post(16'h0004); tick(6);
    clr(16'h0004); tick();
    delay = 3; post(16'h0004); delay = 20; post(16'h0004); tick(6); clr(16'h0004); tick();
    phase = "R11"; rx_hi = 0; delay = 2; post(16'h0002); tick(5);
    rx_hi = 1; post(16'h0002); tick(4); clr(16'h0002); tick();
    tx_lo = 0; post(16'h0008); tick(4); tx_lo = 1; clr(16'h0008); tick();
    phase = "R10"; delay = 0; post(16'h0004); tick(2); post(16'h0008); tick(2);
    clr(16'h0004); tick(2); clr(16'h0008); tick(2);
    phase = "R5";  post(16'h0010); tick(2); mwr(16'h000F); tick(2);
    mwr(16'h0010); tick(2); mwr(16'h0001); tick(2); mwr(16'h000F); tick(2);
    clr(16'h0010); tick();
    phase = "R9";  delay = 1; int_en = 0; post(16'h0004); tick(4);
    int_en = 1; tick(3); int_en = 0; tick(2); int_en = 1; tick(2); clr(16'h0004); tick();
    phase = "R4";  delay = 10; post(16'h0004); tick(3); clr(16'h0004); tick(12);
    phase = "R12"; delay = 0; post(16'h0004); tick(); mwr(16'h00F0); cmdr(); tick(3);
    finish_run();
  end
endmodule